// File: doc/BRIEF.md
# ATA Command Sequencer with Scaled Poll Timeouts

This block runs one ATA command from start to finish over a bridge that reaches the drive's task-file registers one byte at a time. A `go` pulse latches an opcode, a 28-bit LBA and a transfer mode. The block then asks a separate link sequencer to connect and polls the status register until the drive reports ready. It writes the seven command registers, polls until the drive is no longer busy, and checks the error bit. After that it either finishes or waits for a data request and hands over to a data-phase unit.

Every poll wait has a two-level limit. The inner count is the number of polls per quarter-second unit. It is derived once, at reset, from a CPU-speed input. The outer count is the number of units: a normal limit for the ready and data-request waits, and a slow limit for command completion. Whatever the outcome, the block asks the link sequencer to disconnect before it reports. It then gives a one-cycle `done` and a result code that stays valid until the next command ends.

Top module: `ata_cmd_seq`

## Requirements
- R1: After `go` the block raises `conn_req` and holds it until `conn_ack`. It then reads status (address base+7) until bit 7 is 0 and bit 6 is 1.
- R2: When the drive is ready, the block writes addresses base+1 to base+7 in that order with these values: 0x00, 0x01, lba[7:0], lba[15:8], lba[23:16], 0xE0 OR lba[27:24], and the opcode.
- R3: After the opcode write, the block reads status until bit 7 is 0, under the slow limit.
- R4: It then reads status once more. If bit 0 is set, it reads the error register at base+1, places that byte on `err_code` and ends with result 1 (command error).
- R5: If bit 0 is clear, `xfer_mode` 0 ends with result 0 (ok) and mode 3 ends with result 1, with no data phase in either case.
- R6: Mode 1 (read) and mode 2 (write) first read status until bit 7 is 0 and bit 3 is 1, under the normal limit. The block then gives a one-cycle `xfer_start` with `xfer_write` high only for mode 2. At `xfer_done` it ends with result 2 (I/O error) if `xfer_ioerr` is set, otherwise result 0.
- R7: A wait that sees UNITS × S failing status reads in a row ends with result 3 (timeout). S is PER_MHZ × `cpu_mhz`, with 0 counted as 1, captured while `rst` is high. Changing `cpu_mhz` later has no effect.
- R8: Every ending raises `disc_req` until `disc_ack`. `done` is high for exactly the cycle after the edge that samples `disc_ack`, and `result` keeps its value until the next `done`.
- R9: After reset, `busy`, `done`, `result`, and every request and strobe output are 0.
- R10: A register request holds `reg_req`, `reg_we`, `reg_addr` and `reg_wdata` steady until `reg_ack`.
- R11: A `go` that arrives while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also captures the poll scaler |
| cpu_mhz | input | MHZ_W | CPU speed in MHz used to scale poll counts |
| go | input | 1 | Start a command (ignored while busy) |
| opcode | input | 8 | ATA command opcode |
| lba | input | 28 | Logical block address |
| xfer_mode | input | 2 | 0 none, 1 read, 2 write, 3 invalid |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle end-of-command pulse |
| result | output | 2 | 0 ok, 1 command error, 2 I/O error, 3 timeout |
| err_code | output | 8 | Error register value of the last failed command |
| conn_req | output | 1 | Connect request to link sequencer |
| conn_ack | input | 1 | Connect acknowledge |
| disc_req | output | 1 | Disconnect request to link sequencer |
| disc_ack | input | 1 | Disconnect acknowledge |
| reg_req | output | 1 | Register access request |
| reg_we | output | 1 | 1 write, 0 read |
| reg_addr | output | AW | Task-file register address |
| reg_wdata | output | 8 | Write data |
| reg_ack | input | 1 | Access complete; read data valid with it |
| reg_rdata | input | 8 | Read data |
| xfer_start | output | 1 | One-cycle start for data-phase unit |
| xfer_write | output | 1 | Data phase direction, 1 = write |
| xfer_done | input | 1 | Data phase finished |
| xfer_ioerr | input | 1 | Data phase failed, valid with xfer_done |

## Verification
Every register access takes two cycles: `reg_req` rises one edge after the access is chosen, and the edge that samples `reg_ack` acts on the result. A failed poll reissues after a further cycle, so poll counts at the timeout limit are counted per access, not per cycle. `done` and the new `result` are due exactly one cycle after the edge that samples `disc_ack`. The bench records the cycle of its acknowledge and compares it with the cycle in which it sees `done`, sampling on the falling edge. Timeout limits are swept across poll counts just below and at the limit for three speed settings, with the limit computed as units × per-MHz × max(speed, 1).

// File: rtl/ata_seq_pkg.sv
package ata_seq_pkg;

  localparam int LBA_W = 28;

  typedef enum logic [1:0] {
    RES_OK      = 2'd0,
    RES_CMDERR  = 2'd1,
    RES_IOERR   = 2'd2,
    RES_TIMEOUT = 2'd3
  } res_e;

  typedef enum logic [1:0] {
    XM_NONE  = 2'd0,
    XM_READ  = 2'd1,
    XM_WRITE = 2'd2,
    XM_BAD   = 2'd3
  } xmode_e;

  typedef enum logic [3:0] {
    S_IDLE, S_CONN, S_RDY, S_LOAD, S_BSY, S_CHK, S_ERRRD, S_DRQ, S_XFER, S_DISC
  } state_e;

  // status bit positions decoded by the waits
  localparam int SB_BUSY = 7;
  localparam int SB_RDY  = 6;
  localparam int SB_DRQ  = 3;
  localparam int SB_ERR  = 0;

endpackage

// File: rtl/ata_seq_scaler.sv
module ata_seq_scaler #(
  parameter int PER_MHZ = 511,
  parameter int MHZ_W   = 8,
  parameter int SCL_W   = 17
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [MHZ_W-1:0] cpu_mhz,
  output logic [SCL_W-1:0] scaler_o
);

  logic [SCL_W-1:0] scaler_q;
  logic [SCL_W-1:0] mhz_eff;

  assign mhz_eff = (cpu_mhz == '0) ? SCL_W'(1) : SCL_W'(cpu_mhz);

  // captured only while reset is held; constant afterwards
  always_ff @(posedge clk) begin
    if (rst) scaler_q <= SCL_W'(PER_MHZ) * mhz_eff;
  end

  assign scaler_o = scaler_q;

  // R7
  scaler_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> $stable(scaler_q));

endmodule

// File: rtl/ata_seq_wait_timer.sv
module ata_seq_wait_timer #(
  parameter int SCL_W  = 17,
  parameter int UNIT_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [UNIT_W-1:0] units,
  input  logic [SCL_W-1:0]  scaler,
  input  logic              step,
  output logic              last_o
);

  logic [SCL_W-1:0]  inner_q;
  logic [UNIT_W-1:0] outer_q;
  logic              active_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      inner_q  <= '0;
      outer_q  <= '0;
      active_q <= 1'b0;
    end else if (load) begin
      inner_q  <= scaler;
      outer_q  <= units;
      active_q <= 1'b1;
    end else if (step) begin
      if (inner_q > SCL_W'(1)) begin
        inner_q <= inner_q - SCL_W'(1);
      end else if (outer_q > UNIT_W'(1)) begin
        outer_q <= outer_q - UNIT_W'(1);
        inner_q <= scaler;
      end
    end
  end

  assign last_o = active_q && (inner_q == SCL_W'(1)) && (outer_q == UNIT_W'(1));

  // R7
  step_armed_chk: assert property (@(posedge clk) disable iff (rst)
    step |-> active_q && !last_o);

  // R7
  count_live_chk: assert property (@(posedge clk) disable iff (rst)
    active_q |-> (inner_q != '0) && (outer_q != '0));

endmodule

// File: rtl/ata_seq_taskfile.sv
module ata_seq_taskfile
  import ata_seq_pkg::*;
(
  input  logic [7:0]       opcode,
  input  logic [LBA_W-1:0] lba,
  input  logic [2:0]       idx,
  output logic [7:0]       data_o
);

  logic [7:0] tf [7];

  assign tf[0] = 8'h00;
  assign tf[1] = 8'h01;

  for (genvar g = 0; g < 3; g++) begin : g_lba
    assign tf[2+g] = lba[8*g +: 8];
  end

  assign tf[5] = 8'hE0 | {4'h0, lba[27:24]};
  assign tf[6] = opcode;

  always_comb begin
    data_o = 8'h00;
    for (int i = 0; i < 7; i++) begin
      if (idx == 3'(i)) data_o = tf[i];
    end
  end

endmodule

// File: rtl/ata_cmd_seq.sv
module ata_cmd_seq
  import ata_seq_pkg::*;
#(
  parameter int PER_MHZ    = 511,
  parameter int NORM_UNITS = 4,
  parameter int SLOW_UNITS = 120,
  parameter int MHZ_W      = 8,
  parameter int AW         = 4,
  parameter int REG_BASE   = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [MHZ_W-1:0] cpu_mhz,
  input  logic             go,
  input  logic [7:0]       opcode,
  input  logic [27:0]      lba,
  input  logic [1:0]       xfer_mode,
  output logic             busy,
  output logic             done,
  output logic [1:0]       result,
  output logic [7:0]       err_code,
  output logic             conn_req,
  input  logic             conn_ack,
  output logic             disc_req,
  input  logic             disc_ack,
  output logic             reg_req,
  output logic             reg_we,
  output logic [AW-1:0]    reg_addr,
  output logic [7:0]       reg_wdata,
  input  logic             reg_ack,
  input  logic [7:0]       reg_rdata,
  output logic             xfer_start,
  output logic             xfer_write,
  input  logic             xfer_done,
  input  logic             xfer_ioerr
);

  localparam int SCL_W  = $clog2(PER_MHZ + 1) + MHZ_W;
  localparam int UNIT_W = $clog2(((SLOW_UNITS > NORM_UNITS) ? SLOW_UNITS : NORM_UNITS) + 1);
  localparam logic [AW-1:0] A_STAT = AW'(REG_BASE + 7);
  localparam logic [AW-1:0] A_ERR  = AW'(REG_BASE + 1);
  localparam logic [AW-1:0] A_FRST = AW'(REG_BASE + 1);

  state_e           state_q;
  logic [7:0]       op_q;
  logic [LBA_W-1:0] lba_q;
  xmode_e           mode_q;
  logic [2:0]       idx_q;
  logic             inflight_q;
  res_e             res_q;

  logic [SCL_W-1:0]  scaler;
  logic              t_load, t_step, t_last;
  logic [UNIT_W-1:0] t_units;
  logic [7:0]        tf_byte;
  logic              ack_now, in_wait, hit, rw_mode;

  ata_seq_scaler #(.PER_MHZ(PER_MHZ), .MHZ_W(MHZ_W), .SCL_W(SCL_W)) u_scaler (
    .clk(clk), .rst(rst), .cpu_mhz(cpu_mhz), .scaler_o(scaler)
  );

  ata_seq_wait_timer #(.SCL_W(SCL_W), .UNIT_W(UNIT_W)) u_timer (
    .clk(clk), .rst(rst), .load(t_load), .units(t_units), .scaler(scaler),
    .step(t_step), .last_o(t_last)
  );

  ata_seq_taskfile u_tf (
    .opcode(op_q), .lba(lba_q), .idx(idx_q), .data_o(tf_byte)
  );

  assign ack_now = inflight_q && reg_ack;
  assign in_wait = (state_q == S_RDY) || (state_q == S_BSY) || (state_q == S_DRQ);
  assign rw_mode = (mode_q == XM_READ) || (mode_q == XM_WRITE);

  always_comb begin
    unique case (state_q)
      S_RDY:   hit = !reg_rdata[SB_BUSY] && reg_rdata[SB_RDY];
      S_BSY:   hit = !reg_rdata[SB_BUSY];
      S_DRQ:   hit = !reg_rdata[SB_BUSY] && reg_rdata[SB_DRQ];
      default: hit = 1'b0;
    endcase
  end

  assign t_load = (state_q == S_CONN && conn_ack)
               || (state_q == S_LOAD && ack_now && idx_q == 3'd6)
               || (state_q == S_CHK && ack_now && !reg_rdata[SB_ERR] && rw_mode);
  assign t_units = (state_q == S_LOAD) ? UNIT_W'(SLOW_UNITS) : UNIT_W'(NORM_UNITS);
  assign t_step  = in_wait && ack_now && !hit && !t_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= S_IDLE;
      op_q       <= '0;
      lba_q      <= '0;
      mode_q     <= XM_NONE;
      idx_q      <= '0;
      inflight_q <= 1'b0;
      res_q      <= RES_OK;
      busy       <= 1'b0;
      done       <= 1'b0;
      result     <= RES_OK;
      err_code   <= '0;
      conn_req   <= 1'b0;
      disc_req   <= 1'b0;
      reg_req    <= 1'b0;
      reg_we     <= 1'b0;
      reg_addr   <= '0;
      reg_wdata  <= '0;
      xfer_start <= 1'b0;
      xfer_write <= 1'b0;
    end else begin
      done       <= 1'b0;
      xfer_start <= 1'b0;
      unique case (state_q)
        S_IDLE: begin
          if (go) begin
            op_q     <= opcode;
            lba_q    <= lba;
            mode_q   <= xmode_e'(xfer_mode);
            busy     <= 1'b1;
            err_code <= '0;
            conn_req <= 1'b1;
            state_q  <= S_CONN;
          end
        end
        S_CONN: begin
          if (conn_ack) begin
            conn_req   <= 1'b0;
            inflight_q <= 1'b0;
            state_q    <= S_RDY;
          end
        end
        S_RDY, S_BSY, S_DRQ: begin
          if (!inflight_q) begin
            reg_req    <= 1'b1;
            reg_we     <= 1'b0;
            reg_addr   <= A_STAT;
            inflight_q <= 1'b1;
          end else if (reg_ack) begin
            reg_req    <= 1'b0;
            inflight_q <= 1'b0;
            if (hit) begin
              if (state_q == S_RDY) begin
                idx_q   <= '0;
                state_q <= S_LOAD;
              end else if (state_q == S_BSY) begin
                state_q <= S_CHK;
              end else begin
                xfer_start <= 1'b1;
                xfer_write <= (mode_q == XM_WRITE);
                state_q    <= S_XFER;
              end
            end else if (t_last) begin
              res_q    <= RES_TIMEOUT;
              disc_req <= 1'b1;
              state_q  <= S_DISC;
            end
          end
        end
        S_LOAD: begin
          if (!inflight_q) begin
            reg_req    <= 1'b1;
            reg_we     <= 1'b1;
            reg_addr   <= A_FRST + AW'(idx_q);
            reg_wdata  <= tf_byte;
            inflight_q <= 1'b1;
          end else if (reg_ack) begin
            reg_req    <= 1'b0;
            reg_we     <= 1'b0;
            inflight_q <= 1'b0;
            if (idx_q == 3'd6) state_q <= S_BSY;
            else               idx_q   <= idx_q + 3'd1;
          end
        end
        S_CHK: begin
          if (!inflight_q) begin
            reg_req    <= 1'b1;
            reg_we     <= 1'b0;
            reg_addr   <= A_STAT;
            inflight_q <= 1'b1;
          end else if (reg_ack) begin
            reg_req    <= 1'b0;
            inflight_q <= 1'b0;
            if (reg_rdata[SB_ERR]) begin
              state_q <= S_ERRRD;
            end else if (rw_mode) begin
              state_q <= S_DRQ;
            end else begin
              res_q    <= (mode_q == XM_NONE) ? RES_OK : RES_CMDERR;
              disc_req <= 1'b1;
              state_q  <= S_DISC;
            end
          end
        end
        S_ERRRD: begin
          if (!inflight_q) begin
            reg_req    <= 1'b1;
            reg_we     <= 1'b0;
            reg_addr   <= A_ERR;
            inflight_q <= 1'b1;
          end else if (reg_ack) begin
            reg_req    <= 1'b0;
            inflight_q <= 1'b0;
            err_code   <= reg_rdata;
            res_q      <= RES_CMDERR;
            disc_req   <= 1'b1;
            state_q    <= S_DISC;
          end
        end
        S_XFER: begin
          if (xfer_done) begin
            res_q    <= xfer_ioerr ? RES_IOERR : RES_OK;
            disc_req <= 1'b1;
            state_q  <= S_DISC;
          end
        end
        S_DISC: begin
          if (disc_ack) begin
            disc_req <= 1'b0;
            done     <= 1'b1;
            busy     <= 1'b0;
            result   <= res_q;
            state_q  <= S_IDLE;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    reg_req && !reg_ack |=> reg_req && $stable(reg_addr) && $stable(reg_we) && $stable(reg_wdata));

  // R8
  done_after_disc_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(disc_ack) && !busy);

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R8
  link_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(conn_req && disc_req));

  // R6
  xfer_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    xfer_start |=> !xfer_start);

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !reg_req && !conn_req && !disc_req && !xfer_start);

  // R8
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(result));

endmodule

// File: tb/ata_cmd_seq_tb.sv
module ata_cmd_seq_tb;

  localparam int PER  = 3;
  localparam int NORM = 2;
  localparam int SLOW = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  cpu_mhz = 8'd2;
  logic        go = 1'b0;
  logic [7:0]  opcode = '0;
  logic [27:0] lba = '0;
  logic [1:0]  xfer_mode = '0;
  logic        busy, done;
  logic [1:0]  result;
  logic [7:0]  err_code;
  logic        conn_req, disc_req, reg_req, reg_we, xfer_start, xfer_write;
  logic        conn_ack = 1'b0, disc_ack = 1'b0, reg_ack = 1'b0;
  logic        xfer_done = 1'b0, xfer_ioerr = 1'b0;
  logic [3:0]  reg_addr;
  logic [7:0]  reg_wdata, reg_rdata = '0;

  ata_cmd_seq #(.PER_MHZ(PER), .NORM_UNITS(NORM), .SLOW_UNITS(SLOW)) u_dut (
    .clk(clk), .rst(rst), .cpu_mhz(cpu_mhz), .go(go), .opcode(opcode), .lba(lba),
    .xfer_mode(xfer_mode), .busy(busy), .done(done), .result(result), .err_code(err_code),
    .conn_req(conn_req), .conn_ack(conn_ack), .disc_req(disc_req), .disc_ack(disc_ack),
    .reg_req(reg_req), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_ack(reg_ack), .reg_rdata(reg_rdata), .xfer_start(xfer_start),
    .xfer_write(xfer_write), .xfer_done(xfer_done), .xfer_ioerr(xfer_ioerr)
  );

  always #2.5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_checks = 0, n_err = 0;
  bit finished = 0;

  // device model configuration and logs
  int rf = 0, bf = 0, df = 0;
  bit eb = 0, xe = 0;
  logic [7:0] ev = '0;
  int stage = 0, rd0 = 0, rd1 = 0, rd2 = 0, n_errrd = 0;
  int n_wr = 0, n_conn = 0, n_disc = 0, n_xs = 0, disc_cyc = 0, xcnt = 0;
  bit xw = 0;
  logic [3:0] wr_addr [16];
  logic [7:0] wr_data [16];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
    end
  endtask

  // responder: link, register bridge and data-phase models
  initial begin
    bit cp, dp, rp;
    cp = 0; dp = 0; rp = 0;
    forever begin
      @(negedge clk);
      conn_ack = 0; disc_ack = 0; reg_ack = 0; xfer_done = 0;
      if (conn_req && !cp) begin conn_ack = 1; n_conn++; end
      if (disc_req && !dp) begin disc_ack = 1; n_disc++; disc_cyc = cyc; end
      if (reg_req && !rp) begin
        reg_ack = 1;
        if (reg_we) begin
          if (n_wr < 16) begin wr_addr[n_wr] = reg_addr; wr_data[n_wr] = reg_wdata; end
          n_wr++;
          if (reg_addr == 4'd7) stage = 1;
        end else if (reg_addr == 4'd7) begin
          if (stage == 0) begin
            rd0++; reg_rdata = (rd0 <= rf) ? 8'h80 : 8'h40;
          end else if (stage == 1) begin
            rd1++; reg_rdata = (rd1 <= bf) ? 8'h80 : (8'h50 | {7'd0, eb});
            if (rd1 == bf + 2) stage = 2;
          end else begin
            rd2++; reg_rdata = (rd2 <= df) ? 8'h50 : 8'h58;
          end
        end else if (reg_addr == 4'd1) begin
          n_errrd++; reg_rdata = ev;
        end else begin
          reg_rdata = 8'h00;
        end
      end
      if (xfer_start) begin
        n_xs++; xw = xfer_write; xcnt = 3;
      end else if (xcnt > 0) begin
        xcnt--;
        if (xcnt == 0) begin xfer_done = 1; xfer_ioerr = xe; end
      end
      cp = conn_ack; dp = disc_ack; rp = reg_ack;
    end
  end

  task automatic do_reset(input int mhz);
    @(negedge clk);
    cpu_mhz = 8'(mhz);
    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
  endtask

  task automatic run_cmd(input logic [7:0] op, input logic [27:0] a, input logic [1:0] m,
                         input int r0, input int b0, input int d0, input bit e0,
                         input logic [7:0] v0, input bit x0, input bit dbl);
    int w;
    rf = r0; bf = b0; df = d0; eb = e0; ev = v0; xe = x0;
    stage = 0; rd0 = 0; rd1 = 0; rd2 = 0; n_errrd = 0; n_wr = 0;
    n_conn = 0; n_disc = 0; n_xs = 0; xw = 0;
    opcode = op; lba = a; xfer_mode = m;
    go = 1;
    @(negedge clk);
    go = 0;
    if (dbl) begin
      repeat (6) @(negedge clk);
      opcode = ~op; xfer_mode = 2'd3; go = 1;
      @(negedge clk);
      go = 0;
    end
    w = 0;
    while (!done && w < 5000) begin @(negedge clk); w++; end
    chk(done == 1'b1, "R8 done seen", int'(done), 1);
    chk(cyc == disc_cyc + 1, "R8 done latency", cyc, disc_cyc + 1);
    chk(n_disc == 1, "R8 disconnect count", n_disc, 1);
  endtask

  function automatic int lim(input int mhz, input int units);
    return PER * ((mhz == 0) ? 1 : mhz) * units;
  endfunction

  initial begin
    logic [27:0] a;
    logic [7:0]  exp_tf [7];
    int L, LS;
    do_reset(2);
    // R9 reset state
    chk(busy == 0 && done == 0 && result == 0, "R9 status idle", {busy, done, result}, 0);
    chk(reg_req == 0 && conn_req == 0 && disc_req == 0 && xfer_start == 0, "R9 requests idle",
        {reg_req, conn_req, disc_req, xfer_start}, 0);

    // R1 R2 R5 R11: basic no-data command with a second go during it
    a = 28'hA5B3C7D;
    run_cmd(8'hC5, a, 2'd0, 3, 2, 0, 0, 8'h00, 0, 1);
    chk(result == 2'd0, "R5 none ok", result, 0);
    chk(n_conn == 1, "R11 one connect", n_conn, 1);
    chk(rd0 == 4, "R1 ready polls", rd0, 4);
    chk(rd1 == 4, "R3 busy polls plus check", rd1, 4);
    chk(n_wr == 7, "R2 write count", n_wr, 7);
    exp_tf[0] = 8'h00; exp_tf[1] = 8'h01; exp_tf[2] = a[7:0]; exp_tf[3] = a[15:8];
    exp_tf[4] = a[23:16]; exp_tf[5] = 8'hE0 | {4'h0, a[27:24]}; exp_tf[6] = 8'hC5;
    for (int i = 0; i < 7; i++) begin
      chk(wr_addr[i] == 4'(i + 1), "R2 write address", wr_addr[i], i + 1);
      chk(wr_data[i] == exp_tf[i], "R2 write data", wr_data[i], exp_tf[i]);
    end
    chk(n_xs == 0, "R5 no data phase", n_xs, 0);
    repeat (3) @(negedge clk);
    chk(result == 2'd0 && busy == 0, "R8 result held", result, 0);

    // R4 error bit
    run_cmd(8'h20, 28'h0000123, 2'd1, 0, 1, 0, 1, 8'h24, 0, 0);
    chk(result == 2'd1, "R4 command error", result, 1);
    chk(err_code == 8'h24, "R4 error register", err_code, 8'h24);
    chk(n_errrd == 1, "R4 error read count", n_errrd, 1);
    chk(n_xs == 0, "R4 no data phase", n_xs, 0);

    // R5 invalid mode
    run_cmd(8'h30, 28'h0FFFFFF, 2'd3, 0, 0, 0, 0, 8'h00, 0, 0);
    chk(result == 2'd1, "R5 invalid mode", result, 1);
    chk(n_xs == 0 && n_errrd == 0, "R5 invalid mode no phase", n_xs + n_errrd, 0);

    // R6 read and write data phases
    run_cmd(8'h20, 28'h0000001, 2'd1, 0, 0, 2, 0, 8'h00, 0, 0);
    chk(result == 2'd0, "R6 read ok", result, 0);
    chk(n_xs == 1 && xw == 0, "R6 read start", {n_xs[3:0], xw}, 2);
    chk(rd2 == 3, "R6 drq polls", rd2, 3);
    run_cmd(8'h30, 28'h0000002, 2'd2, 1, 1, 1, 0, 8'h00, 1, 0);
    chk(result == 2'd2, "R6 write ioerr", result, 2);
    chk(n_xs == 1 && xw == 1, "R6 write start", {n_xs[3:0], xw}, 3);

    // R7 timeout sweeps over speed settings
    for (int mhz = 0; mhz < 3; mhz++) begin
      do_reset(mhz);
      L = lim(mhz, NORM); LS = lim(mhz, SLOW);
      for (int r = L - 2; r <= L + 1; r++) begin
        run_cmd(8'hEC, 28'h0, 2'd0, r, 0, 0, 0, 8'h00, 0, 0);
        if (r < L) begin
          chk(result == 2'd0, "R7 ready within limit", result, 0);
        end else begin
          chk(result == 2'd3, "R7 ready timeout", result, 3);
          chk(rd0 == L, "R7 ready poll count", rd0, L);
          chk(n_wr == 0, "R7 no loads after timeout", n_wr, 0);
        end
      end
      run_cmd(8'hEC, 28'h0, 2'd0, 0, LS - 1, 0, 0, 8'h00, 0, 0);
      chk(result == 2'd0, "R3 busy within slow limit", result, 0);
      run_cmd(8'hEC, 28'h0, 2'd0, 0, LS, 0, 0, 8'h00, 0, 0);
      chk(result == 2'd3, "R3 busy timeout", result, 3);
      chk(rd1 == LS, "R3 busy poll count", rd1, LS);
      run_cmd(8'h20, 28'h0, 2'd1, 0, 0, L - 1, 0, 8'h00, 0, 0);
      chk(result == 2'd0, "R6 drq within limit", result, 0);
      run_cmd(8'h20, 28'h0, 2'd1, 0, 0, L, 0, 8'h00, 0, 0);
      chk(result == 2'd3, "R7 drq timeout", result, 3);
      chk(rd2 == L && n_xs == 0, "R7 drq poll count", rd2, L);
    end

    // R7 speed input ignored after reset
    do_reset(2);
    cpu_mhz = 8'd0;
    run_cmd(8'hEC, 28'h0, 2'd0, 100, 0, 0, 0, 8'h00, 0, 0);
    chk(rd0 == lim(2, NORM), "R7 scaler latched", rd0, lim(2, NORM));

    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++; n_err++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    finish_run();
  end

endmodule